// File: doc/BRIEF.md
# Start Holdoff Controller

This block decides when a processing channel leaves sleep after a synchronisation event. Software programs a 16-bit holdoff count. A start event can come from a one-cycle software strobe or from an asynchronous pin. A rising pin edge passes through a two-flop synchroniser and an edge detector first. Either source loads the programmed count into one shared down-counter. When the count arrives at one, the block raises a run enable that wakes the downstream data path.

A holdoff of zero disables synchronisation: events are then dropped with no side effect. A holdoff of one starts the channel on the edge that accepts the event. Each accepted event also produces a one-cycle clear pulse on every data path whose sync-mask bit is set. A path whose mask bit is clear is never cleared.

Top module: `hold_start_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `run_en` is 0 and `path_clr` is all zeros. Reset is asynchronous and active low.
- R2: If a software strobe is sampled at clock edge E while `cfg_hold` holds H ≥ 2, then `run_en` is 0 after edge E and after each edge up to E+H-2. It becomes 1 after edge E+H-1.
- R3: If `sync_pin` goes from 0 to 1, the event is accepted on the third rising clock edge after the pin is first sampled high. Timing from that edge on follows R2 and R4. Holding the pin high never produces a second event.
- R4: If an event is accepted while `cfg_hold` is 1, `run_en` is 1 after that same edge.
- R5: If an event arrives while `cfg_hold` is 0, it is ignored. No clear pulse is produced. An ongoing countdown continues unchanged, and `run_en` keeps its value.
- R6: Once `run_en` is 1, it stays 1 until reset or until an event is accepted with a holdoff of 2 or more.
- R7: An event accepted during a countdown or while running restarts the countdown from the current `cfg_hold`. `run_en` drops to 0 after that edge when H ≥ 2.
- R8: After an accepted event at edge E, `path_clr` equals `cfg_mask` as sampled at E for exactly one cycle. Bit i of `path_clr` is path i. Bits whose mask is 0 never pulse.
- R9: A software strobe and a pin event on the same edge are one event: there is one load and one clear pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_hold | input | HOLD_W (16) | Programmed holdoff count |
| cfg_mask | input | NPATH (2) | Per-path sync-mask bits |
| sw_sync | input | 1 | One-cycle software start strobe |
| sync_pin | input | 1 | Asynchronous start pin |
| run_en | output | 1 | Channel running (1) or sleeping (0) |
| path_clr | output | NPATH (2) | One-cycle clear pulse per masked path |

## Verification
The assertions check several rules on every cycle. A holdoff of one gives an immediate start, and a holdoff of two or more drops the run enable. An event with a zero holdoff never clears a path. The run enable never falls without an accepted event. A clear pulse appears only after an accepted event and only on masked paths. Only the bench scenarios can show the exact countdown length, the three-edge pin latency, the absence of retriggering from a held pin, a restart in mid-count, and the merging of two sources that arrive together.

// File: rtl/hold_pkg.sv
package hold_pkg;
    typedef enum logic [1:0] {
        ST_SLEEP = 2'd0,
        ST_COUNT = 2'd1,
        ST_RUN   = 2'd2
    } chan_state_e;
endpackage

// File: rtl/hold_pin_sync.sv
module hold_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic rise
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              last;
    } pin_regs_t;

    pin_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        r_d.sh[0] = pin_async;
        for (int i = 1; i < STAGES; i++) begin
            r_d.sh[i] = r_q.sh[i-1];
        end
        r_d.last = r_q.sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // rising edge seen at the synchroniser output
    assign rise = r_q.sh[STAGES-1] & ~r_q.last;
endmodule

// File: rtl/hold_sync_qual.sv
module hold_sync_qual #(
    parameter int HOLD_W = 16
) (
    input  logic              sw_sync,
    input  logic              pin_rise,
    input  logic [HOLD_W-1:0] cfg_hold,
    output logic              sync_acc,
    output logic [HOLD_W-1:0] load_val
);
    logic any_src;
    logic hold_nz;

    always_comb begin
        any_src  = sw_sync | pin_rise;
        hold_nz  = |cfg_hold;
        sync_acc = any_src & hold_nz;
        load_val = cfg_hold;
    end
endmodule

// File: rtl/hold_counter.sv
module hold_counter
    import hold_pkg::*;
#(
    parameter int HOLD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [HOLD_W-1:0] load_val,
    output logic              run
);
    localparam logic [HOLD_W-1:0] ONE = HOLD_W'(1);
    localparam logic [HOLD_W-1:0] TWO = HOLD_W'(2);

    typedef struct packed {
        chan_state_e       st;
        logic [HOLD_W-1:0] cnt;
    } cnt_regs_t;

    cnt_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load) begin
            if (load_val == ONE) begin
                r_d.st  = ST_RUN;
                r_d.cnt = '0;
            end else begin
                r_d.st  = ST_COUNT;
                r_d.cnt = load_val;
            end
        end else begin
            unique case (r_q.st)
                ST_COUNT: begin
                    if (r_q.cnt <= TWO) begin
                        r_d.st  = ST_RUN;
                        r_d.cnt = '0;
                    end else begin
                        r_d.cnt = r_q.cnt - ONE;
                    end
                end
                ST_RUN:   r_d = r_q;
                default:  r_d = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= ST_SLEEP;
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign run = (r_q.st == ST_RUN);
endmodule

// File: rtl/hold_clr_gen.sv
module hold_clr_gen #(
    parameter int NPATH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [NPATH-1:0] mask,
    output logic [NPATH-1:0] clr
);
    typedef struct packed {
        logic [NPATH-1:0] pulse;
    } clr_regs_t;

    clr_regs_t r_d, r_q;
    logic [NPATH-1:0] bit_d;

    for (genvar g = 0; g < NPATH; g++) begin : g_path
        assign bit_d[g] = fire & mask[g];
    end

    always_comb begin
        r_d       = r_q;
        r_d.pulse = bit_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign clr = r_q.pulse;
endmodule

// File: rtl/hold_start_ctrl.sv
module hold_start_ctrl #(
    parameter int HOLD_W     = 16,
    parameter int NPATH      = 2,
    parameter int PIN_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HOLD_W-1:0] cfg_hold,
    input  logic [NPATH-1:0]  cfg_mask,
    input  logic              sw_sync,
    input  logic              sync_pin,
    output logic              run_en,
    output logic [NPATH-1:0]  path_clr
);
    logic              pin_rise;
    logic              sync_acc;
    logic [HOLD_W-1:0] load_val;

    hold_pin_sync #(.STAGES(PIN_STAGES)) u_pin (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (sync_pin),
        .rise      (pin_rise)
    );

    hold_sync_qual #(.HOLD_W(HOLD_W)) u_qual (
        .sw_sync  (sw_sync),
        .pin_rise (pin_rise),
        .cfg_hold (cfg_hold),
        .sync_acc (sync_acc),
        .load_val (load_val)
    );

    hold_counter #(.HOLD_W(HOLD_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sync_acc),
        .load_val (load_val),
        .run      (run_en)
    );

    hold_clr_gen #(.NPATH(NPATH)) u_clr (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (sync_acc),
        .mask  (cfg_mask),
        .clr   (path_clr)
    );
endmodule

// File: rtl/hold_start_chk.sv
module hold_start_chk #(
    parameter int HOLD_W = 16,
    parameter int NPATH  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [HOLD_W-1:0] cfg_hold,
    input logic [NPATH-1:0]  cfg_mask,
    input logic              sw_sync,
    input logic              pin_rise,
    input logic              sync_acc,
    input logic              run_en,
    input logic [NPATH-1:0]  path_clr
);
    // R4
    imm_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_acc && cfg_hold == HOLD_W'(1)) |=> run_en);

    // R2
    long_hold_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_acc && cfg_hold > HOLD_W'(1)) |=> !run_en);

    // R5
    zero_hold_noclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sw_sync || pin_rise) && cfg_hold == '0) |=> (path_clr == '0));

    // R6
    run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !sync_acc) |=> run_en);

    // R8
    clr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (path_clr != '0) |-> $past(sync_acc));

    // R8
    clr_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (path_clr != '0) |-> ((path_clr & ~$past(cfg_mask)) == '0));
endmodule

bind hold_start_ctrl hold_start_chk #(.HOLD_W(HOLD_W), .NPATH(NPATH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_hold (cfg_hold),
    .cfg_mask (cfg_mask),
    .sw_sync  (sw_sync),
    .pin_rise (pin_rise),
    .sync_acc (sync_acc),
    .run_en   (run_en),
    .path_clr (path_clr)
);

// File: tb/sim_hold_start_ctrl.sv
`timescale 1ns/1ps
module sim_hold_start_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_hold = '0;
    logic [1:0]  cfg_mask = '0;
    logic        sw_sync = 1'b0;
    logic        sync_pin = 1'b0;
    logic        run_en;
    logic [1:0]  path_clr;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        int        at;
        bit        chk_run;
        bit        run;
        bit        chk_clr;
        logic [1:0] clr;
        string     req;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;

    hold_start_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_hold(cfg_hold), .cfg_mask(cfg_mask),
        .sw_sync(sw_sync), .sync_pin(sync_pin), .run_en(run_en), .path_clr(path_clr)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compare outputs against due scoreboard items
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].at == cyc) begin
                if (sb[i].chk_run) begin
                    checks++;
                    if (run_en !== sb[i].run) begin
                        errors++;
                        $display("FAIL %s cyc=%0d run_en actual=%0b expected=%0b",
                                 sb[i].req, cyc, run_en, sb[i].run);
                    end
                end
                if (sb[i].chk_clr) begin
                    checks++;
                    if (path_clr !== sb[i].clr) begin
                        errors++;
                        $display("FAIL %s cyc=%0d path_clr actual=%b expected=%b",
                                 sb[i].req, cyc, path_clr, sb[i].clr);
                    end
                end
                sb.delete(i);
            end
        end
    end

    task automatic push_run(int at, bit r, string q);
        sb.push_back('{at: at, chk_run: 1'b1, run: r, chk_clr: 1'b0, clr: 2'b00, req: q});
    endtask

    task automatic push_clr(int at, logic [1:0] c, string q);
        sb.push_back('{at: at, chk_run: 1'b0, run: 1'b0, chk_clr: 1'b1, clr: c, req: q});
    endtask

    // expectations for an event accepted at edge e
    task automatic expect_evt(int e, logic [15:0] h, logic [1:0] m, bit full, string q);
        if (h == 0) begin
            push_clr(e, 2'b00, "R5");
            push_clr(e + 1, 2'b00, "R5");
            return;
        end
        push_clr(e, m, "R8");
        push_clr(e + 1, 2'b00, "R8");
        if (h == 1) begin
            push_run(e, 1'b1, "R4");
            if (full) push_run(e + 1, 1'b1, "R4");
        end else begin
            push_run(e, 1'b0, "R7");
            if (full) begin
                push_run(e + int'(h) - 2, 1'b0, q);
                push_run(e + int'(h) - 1, 1'b1, q);
                push_run(e + int'(h), 1'b1, q);
            end
        end
    endtask

    task automatic fire_sw(logic [15:0] h, logic [1:0] m, bit full, string q, output int e);
        @(negedge clk);
        cfg_hold = h;
        cfg_mask = m;
        sw_sync  = 1'b1;
        e = cyc + 1;
        expect_evt(e, h, m, full, q);
        @(negedge clk);
        sw_sync = 1'b0;
    endtask

    task automatic direct_check(bit ok, string q, string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s", q, what);
        end
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
    endtask

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int e, e2;
        // R1: reset state
        repeat (3) @(negedge clk);
        direct_check(run_en === 1'b0 && path_clr === 2'b00, "R1",
            $sformatf("during reset run=%0b clr=%b expected 0/00", run_en, path_clr));
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        direct_check(run_en === 1'b0 && path_clr === 2'b00, "R1",
            $sformatf("after reset run=%0b clr=%b expected 0/00", run_en, path_clr));

        // R2: software sync with holdoff 5, then R6 sticky run
        fire_sw(16'd5, 2'b01, 1'b1, "R2", e);
        for (int k = 5; k < 25; k++) push_run(e + k, 1'b1, "R6");
        drain();

        // R5: zero holdoff while running is ignored
        fire_sw(16'd0, 2'b11, 1'b0, "R5", e);
        push_run(e, 1'b1, "R5");
        push_run(e + 1, 1'b1, "R5");
        drain();

        // R7: restart in mid-count, then R5 during countdown
        fire_sw(16'd8, 2'b10, 1'b0, "R7", e);
        repeat (2) @(negedge clk);
        fire_sw(16'd6, 2'b01, 1'b1, "R7", e2);
        push_run(e + 7, 1'b0, "R7");
        fire_sw(16'd0, 2'b11, 1'b0, "R5", e);
        drain();

        // R4: immediate start from sleep
        fire_sw(16'd9, 2'b00, 1'b0, "R7", e);
        fire_sw(16'd1, 2'b11, 1'b1, "R4", e2);
        drain();

        // R3: pin event, three-edge latency, held pin does not retrigger
        @(negedge clk);
        cfg_hold = 16'd4;
        cfg_mask = 2'b11;
        sync_pin = 1'b1;
        e = cyc + 3;
        push_run(e - 1, 1'b1, "R3");
        expect_evt(e, 16'd4, 2'b11, 1'b1, "R3");
        for (int k = 4; k < 16; k++) begin
            push_run(e + k, 1'b1, "R3");
            push_clr(e + k, 2'b00, "R3");
        end
        drain();
        sync_pin = 1'b0;
        repeat (4) @(negedge clk);

        // R9: pin and software strobe on the same edge
        @(negedge clk);
        cfg_hold = 16'd3;
        cfg_mask = 2'b01;
        sync_pin = 1'b1;
        e = cyc + 3;
        expect_evt(e, 16'd3, 2'b01, 1'b1, "R9");
        push_clr(e + 1, 2'b00, "R9");
        repeat (2) @(negedge clk);
        sw_sync = 1'b1;
        @(negedge clk);
        sw_sync = 1'b0;
        drain();
        sync_pin = 1'b0;

        // R1: reset while running
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        #1;
        direct_check(run_en === 1'b0 && path_clr === 2'b00, "R1",
            $sformatf("mid-run reset run=%0b clr=%b expected 0/00", run_en, path_clr));
        @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        direct_check(run_en === 1'b0, "R1",
            $sformatf("sleep after reset run=%0b expected 0", run_en));

        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule